// File: doc/BRIEF.md
# SDRAM Bank Command Sequencer

This block accepts one memory access (bank, row, column, read or write, burst length) or one refresh request at a time and turns it into the shortest legal series of SDRAM commands for a four-bank device. It remembers, for every bank, whether a row is open and which one. From that record it picks one of three paths: the read or write alone when the row is already open, an activate and then the access when the bank is idle, or a precharge, an activate and then the access when the bank holds a different row. A refresh request becomes a precharge of all banks followed by a refresh. After that every bank counts as closed.

The wait from precharge to activate and the wait from activate to read or write are counted by the block's own down-counter. The time a refresh takes to finish is counted the same way. Every other timing rule is left to the surrounding controller. It supplies one enable per command type and per bank, plus one enable each for precharge-all and refresh. A pending command waits in its state until its enable is high and is then issued as a one-cycle pulse. Requests use a valid/ready handshake. A one-cycle done pulse marks the command that finishes each request.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After `rst`, `req_ready` is 1, `cmd_valid` and `done` are 0, and every bank counts as closed, so the first access to a bank issues an activate before its read or write.
- R2: A read or write to a bank whose open row equals the requested row issues only the read (code 3) or write (code 4) command, with no precharge or activate.
- R3: A read or write to a bank holding a different row issues precharge (code 1) of that bank, then activate (code 2), then the read or write, all carrying the request's bank on `cmd_bank`.
- R4: A read or write to a closed bank issues activate then the access. Rows open in other banks stay open, so a later access to such a row issues only the read or write.
- R5: With all enables high, an activate that follows a precharge or a precharge-all is issued exactly TRP cycles after it.
- R6: With all enables high, a read or write that follows an activate is issued exactly TRCD cycles after it.
- R7: A refresh request issues precharge-all (code 5) then refresh (code 6), TRP cycles apart. Afterwards every bank is closed and the next access issues an activate.
- R8: After a refresh command, `req_ready` returns exactly TRFC cycles later. `req_ready` is high only when the sequencer is idle and its counter has expired.
- R9: A pending command is not issued while its enable bit is low; enable bit i belongs to bank i, and the enable of another bank does not release it. Once the enable is high, the command is issued as a single one-cycle `cmd_valid` pulse.
- R10: `done` pulses for exactly one cycle per request, in the same cycle as the read, the write or the refresh command.
- R11: `cmd_addr` carries the row (zero-extended) during an activate and the column (zero-extended) during a read or write. `cmd_burst` carries the request's burst value during a read or write.
- R12: A one-cycle `clr` pulse in the middle of a sequence returns the sequencer to idle, with `req_ready` high on the next cycle, and marks every bank closed.
- R13: Command code 0 means no command and is present whenever `cmd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear back to idle, all banks closed |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_refresh | input | 1 | 1 = refresh request, 0 = access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W (2) | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_burst | input | BURST_W | Burst length value passed with the read or write |
| en_pre | input | NUM_BANKS | Per-bank precharge enable |
| en_act | input | NUM_BANKS | Per-bank activate enable |
| en_rd | input | NUM_BANKS | Per-bank read enable |
| en_wr | input | NUM_BANKS | Per-bank write enable |
| en_pall | input | 1 | Precharge-all enable |
| en_ref | input | 1 | Refresh enable |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 3 | 0 none, 1 precharge, 2 activate, 3 read, 4 write, 5 precharge-all, 6 refresh |
| cmd_bank | output | BANK_W (2) | Bank of the command (0 for precharge-all and refresh) |
| cmd_addr | output | max(ROW_W, COL_W) | Row during an activate, column during a read or write |
| cmd_burst | output | BURST_W | Burst value during a read or write |
| done | output | 1 | One-cycle pulse when a request's final command is issued |

## Verification
The main function is tried with a chain of requests that carry bank state from one request to the next. The chain covers a first access after reset, a row hit, a row conflict in the same bank, a first access to a second bank while the first stays open, a return to the first bank, a refresh, and accesses after the refresh. Between them these tell the three path choices apart and show that open-row state is kept per bank and wiped by refresh. Each command is logged with its cycle, so the gaps prove the internal TRP, TRCD and refresh waits. Directed cases hold one bank's enable low while another bank's enable is high, and pulse clear between an activate and its read to show that the bank was marked closed.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // command codes driven on cmd_code
    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PRE  = 3'd1,
        CMD_ACT  = 3'd2,
        CMD_RD   = 3'd3,
        CMD_WR   = 3'd4,
        CMD_PALL = 3'd5,
        CMD_REF  = 3'd6
    } cmd_e;

    // sequencer states; each non-idle state owns one pending command
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_ACT  = 3'd2,
        ST_RW   = 3'd3,
        ST_PALL = 3'd4,
        ST_REF  = 3'd5
    } state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // shortest path for a request, chosen from the target bank's state
    function automatic state_e first_step(input logic refresh,
                                          input logic bank_open,
                                          input logic row_hit);
        if (refresh)
            return ST_PALL;
        else if (!bank_open)
            return ST_ACT;
        else if (row_hit)
            return ST_RW;
        else
            return ST_PRE;
    endfunction

    function automatic logic ends_request(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR) || (c == CMD_REF);
    endfunction

endpackage

// File: rtl/sdram_seq_delay.sv
module sdram_seq_delay #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             sclr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (sclr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_seq_rowtab.sv
module sdram_seq_rowtab #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              sclr,
    // lookup for an incoming request
    input  logic [BANK_W-1:0] q_bank,
    input  logic [ROW_W-1:0]  q_row,
    output logic              q_open,
    output logic              q_hit,
    // updates from issued commands
    input  logic [BANK_W-1:0] u_bank,
    input  logic [ROW_W-1:0]  u_row,
    input  logic              u_act,
    input  logic              u_pre,
    input  logic              u_pall
);
    logic [NUM_BANKS-1:0] open_vec;
    logic [ROW_W-1:0]     row_arr [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             open_b;
        logic [ROW_W-1:0] row_b;
        logic             sel_b;

        assign sel_b = (u_bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (sclr || u_pall) begin
                open_b <= 1'b0;
            end else if (sel_b && u_pre) begin
                open_b <= 1'b0;
            end else if (sel_b && u_act) begin
                open_b <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sclr)
                row_b <= '0;
            else if (sel_b && u_act)
                row_b <= u_row;
        end

        assign open_vec[b] = open_b;
        assign row_arr[b]  = row_b;
    end

    assign q_open = open_vec[q_bank];
    assign q_hit  = q_open && (row_arr[q_bank] == q_row);
endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
    import sdram_seq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 sclr,
    input  logic                 start,
    input  state_e               start_state,
    input  logic [BANK_W-1:0]    bank,
    input  logic                 write,
    input  logic                 cnt_expired,
    input  logic [NUM_BANKS-1:0] en_pre,
    input  logic [NUM_BANKS-1:0] en_act,
    input  logic [NUM_BANKS-1:0] en_rd,
    input  logic [NUM_BANKS-1:0] en_wr,
    input  logic                 en_pall,
    input  logic                 en_ref,
    output logic                 fire,
    output cmd_e                 code,
    output logic                 idle
);
    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        code    = CMD_NOP;
        unique case (state_q)
            ST_IDLE: begin
                if (start)
                    state_d = start_state;
            end
            ST_PRE: begin
                if (cnt_expired && en_pre[bank]) begin
                    fire    = 1'b1;
                    code    = CMD_PRE;
                    state_d = ST_ACT;
                end
            end
            ST_ACT: begin
                if (cnt_expired && en_act[bank]) begin
                    fire    = 1'b1;
                    code    = CMD_ACT;
                    state_d = ST_RW;
                end
            end
            ST_RW: begin
                if (cnt_expired && (write ? en_wr[bank] : en_rd[bank])) begin
                    fire    = 1'b1;
                    code    = write ? CMD_WR : CMD_RD;
                    state_d = ST_IDLE;
                end
            end
            ST_PALL: begin
                if (cnt_expired && en_pall) begin
                    fire    = 1'b1;
                    code    = CMD_PALL;
                    state_d = ST_REF;
                end
            end
            ST_REF: begin
                if (cnt_expired && en_ref) begin
                    fire    = 1'b1;
                    code    = CMD_REF;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (sclr)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign idle = (state_q == ST_IDLE);
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int BURST_W   = 3,
    parameter int TRP       = 3,
    parameter int TRCD      = 2,
    parameter int TRFC      = 6,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_refresh,
    input  logic                 req_write,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic [COL_W-1:0]     req_col,
    input  logic [BURST_W-1:0]   req_burst,
    input  logic [NUM_BANKS-1:0] en_pre,
    input  logic [NUM_BANKS-1:0] en_act,
    input  logic [NUM_BANKS-1:0] en_rd,
    input  logic [NUM_BANKS-1:0] en_wr,
    input  logic                 en_pall,
    input  logic                 en_ref,
    output logic                 cmd_valid,
    output logic [2:0]           cmd_code,
    output logic [BANK_W-1:0]    cmd_bank,
    output logic [ADDR_W-1:0]    cmd_addr,
    output logic [BURST_W-1:0]   cmd_burst,
    output logic                 done
);
    localparam int T_MAX = imax(imax(TRP, TRCD), TRFC);
    localparam int CNT_W = $clog2(T_MAX + 1);

    typedef struct packed {
        logic               refresh;
        logic               write;
        logic [BANK_W-1:0]  bank;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic [BURST_W-1:0] burst;
    } req_t;

    logic             sclr;
    logic             accept;
    req_t             req_q;
    logic             q_open, q_hit;
    state_e           start_state;
    logic             fire, idle, cnt_expired;
    cmd_e             code;
    logic             load;
    logic [CNT_W-1:0] load_val;

    assign sclr   = rst | clr;
    assign accept = req_valid & req_ready;

    // capture the request the sequencer works on
    always_ff @(posedge clk) begin
        if (sclr)
            req_q <= '0;
        else if (accept)
            req_q <= '{refresh: req_refresh, write: req_write, bank: req_bank,
                       row: req_row, col: req_col, burst: req_burst};
    end

    sdram_seq_rowtab #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W)
    ) u_rowtab (
        .clk    (clk),
        .sclr   (sclr),
        .q_bank (req_bank),
        .q_row  (req_row),
        .q_open (q_open),
        .q_hit  (q_hit),
        .u_bank (req_q.bank),
        .u_row  (req_q.row),
        .u_act  (fire && code == CMD_ACT),
        .u_pre  (fire && code == CMD_PRE),
        .u_pall (fire && code == CMD_PALL)
    );

    assign start_state = first_step(req_refresh, q_open, q_hit);

    sdram_seq_fsm #(
        .NUM_BANKS (NUM_BANKS)
    ) u_fsm (
        .clk         (clk),
        .sclr        (sclr),
        .start       (accept),
        .start_state (start_state),
        .bank        (req_q.bank),
        .write       (req_q.write),
        .cnt_expired (cnt_expired),
        .en_pre      (en_pre),
        .en_act      (en_act),
        .en_rd       (en_rd),
        .en_wr       (en_wr),
        .en_pall     (en_pall),
        .en_ref      (en_ref),
        .fire        (fire),
        .code        (code),
        .idle        (idle)
    );

    // the wait that follows each issued command
    always_comb begin
        load     = 1'b0;
        load_val = '0;
        if (fire) begin
            unique case (code)
                CMD_PRE, CMD_PALL: begin load = 1'b1; load_val = CNT_W'(TRP - 1);  end
                CMD_ACT:           begin load = 1'b1; load_val = CNT_W'(TRCD - 1); end
                CMD_REF:           begin load = 1'b1; load_val = CNT_W'(TRFC - 1); end
                default:           begin load = 1'b0; load_val = '0;               end
            endcase
        end
    end

    sdram_seq_delay #(
        .CNT_W (CNT_W)
    ) u_delay (
        .clk      (clk),
        .sclr     (sclr),
        .load     (load),
        .load_val (load_val),
        .expired  (cnt_expired)
    );

    assign req_ready = idle & cnt_expired;
    assign cmd_valid = fire;
    assign cmd_code  = code;
    assign done      = fire & ends_request(code);

    always_comb begin
        cmd_bank  = '0;
        cmd_addr  = '0;
        cmd_burst = '0;
        unique case (code)
            CMD_PRE: cmd_bank = req_q.bank;
            CMD_ACT: begin
                cmd_bank = req_q.bank;
                cmd_addr = ADDR_W'(req_q.row);
            end
            CMD_RD, CMD_WR: begin
                cmd_bank  = req_q.bank;
                cmd_addr  = ADDR_W'(req_q.col);
                cmd_burst = req_q.burst;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int TRP       = 3,
    parameter int TRCD      = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 clr,
    input logic                 req_ready,
    input logic                 cmd_valid,
    input logic [2:0]           cmd_code,
    input logic [BANK_W-1:0]    cmd_bank,
    input logic [NUM_BANKS-1:0] en_act,
    input logic                 done
);
    logic [15:0] since_pre, since_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_pre <= '1;
            since_act <= '1;
        end else begin
            if (cmd_valid && (cmd_code == CMD_PRE || cmd_code == CMD_PALL))
                since_pre <= 16'd1;
            else if (since_pre != '1)
                since_pre <= since_pre + 16'd1;
            if (cmd_valid && cmd_code == CMD_ACT)
                since_act <= 16'd1;
            else if (since_act != '1)
                since_act <= since_act + 16'd1;
        end
    end

    // R5
    trp_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_ACT) |-> (since_pre >= 16'(TRP)));

    // R6
    trcd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_code == CMD_RD || cmd_code == CMD_WR)) |-> (since_act >= 16'(TRCD)));

    // R9
    act_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_ACT) |-> en_act[cmd_bank]);

    // R9
    act_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == CMD_ACT) |=> !(cmd_valid && cmd_code == CMD_ACT));

    // R10
    done_with_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cmd_valid && (cmd_code == CMD_RD || cmd_code == CMD_WR || cmd_code == CMD_REF)));

    // R8
    ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !cmd_valid);

    // R12
    clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> req_ready);

    // R13
    nop_code_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> (cmd_code == CMD_NOP));
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
    .NUM_BANKS (NUM_BANKS),
    .TRP       (TRP),
    .TRCD      (TRCD)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_bank  (cmd_bank),
    .en_act    (en_act),
    .done      (done)
);

// File: tb/sdram_cmd_seq_test.sv
`timescale 1ns/100ps
module sdram_cmd_seq_test;
    localparam int ROW_W = 13, COL_W = 10, BURST_W = 3;
    localparam int TRP = 3, TRCD = 2, TRFC = 6;
    localparam logic [2:0] C_PRE = 3'd1, C_ACT = 3'd2, C_RD = 3'd3, C_WR = 3'd4,
                           C_PALL = 3'd5, C_REF = 3'd6;

    logic              clk = 1'b0;
    logic              rst, clr, req_valid, req_ready, req_refresh, req_write;
    logic [1:0]        req_bank;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    logic [BURST_W-1:0] req_burst;
    logic [3:0]        en_pre, en_act, en_rd, en_wr;
    logic              en_pall, en_ref;
    logic              cmd_valid, done;
    logic [2:0]        cmd_code;
    logic [1:0]        cmd_bank;
    logic [12:0]       cmd_addr;
    logic [BURST_W-1:0] cmd_burst;

    always #2 clk = ~clk;

    sdram_cmd_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .BURST_W(BURST_W),
        .TRP(TRP), .TRCD(TRCD), .TRFC(TRFC)
    ) uut (
        .clk(clk), .rst(rst), .clr(clr),
        .req_valid(req_valid), .req_ready(req_ready), .req_refresh(req_refresh),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_burst(req_burst),
        .en_pre(en_pre), .en_act(en_act), .en_rd(en_rd), .en_wr(en_wr),
        .en_pall(en_pall), .en_ref(en_ref),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .cmd_burst(cmd_burst), .done(done)
    );

    int checks = 0, errors = 0, cyc = 0;

    // command log filled by the monitor
    logic [2:0]  lg_code  [8];
    logic [1:0]  lg_bank  [8];
    logic [12:0] lg_addr  [8];
    logic [2:0]  lg_burst [8];
    logic        lg_done  [8];
    int          lg_cyc   [8];
    int          lg_n = 0, done_n = 0;

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge clk) begin
        #1;
        if (cmd_valid && lg_n < 8) begin
            lg_code[lg_n]  = cmd_code;
            lg_bank[lg_n]  = cmd_bank;
            lg_addr[lg_n]  = cmd_addr;
            lg_burst[lg_n] = cmd_burst;
            lg_done[lg_n]  = done;
            lg_cyc[lg_n]   = cyc;
            lg_n = lg_n + 1;
        end
        if (done) done_n = done_n + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic rf, input logic wr, input logic [1:0] bk,
                        input logic [12:0] row, input logic [9:0] col, input logic [2:0] bl);
        @(negedge clk);
        lg_n = 0; done_n = 0;
        req_valid = 1'b1; req_refresh = rf; req_write = wr;
        req_bank = bk; req_row = row; req_col = col; req_burst = bl;
        #1.5;
        while (!req_ready) begin @(negedge clk); #1.5; end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // waits until ready; returns the cycle in which ready is first seen
    task automatic wait_ready(output int at);
        #1.5;
        while (!req_ready) begin @(negedge clk); #1.5; end
        at = cyc;
    endtask

    typedef struct packed {
        logic        rf;
        logic        wr;
        logic [1:0]  bank;
        logic [12:0] row;
        logic [9:0]  col;
        logic [2:0]  burst;
        logic [1:0]  n;
        logic [2:0]  c0;
        logic [2:0]  c1;
        logic [2:0]  c2;
    } vec_t;

    // chained: bank state carries from one entry to the next
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 2'd0, 13'd5, 10'd17,   3'd3, 2'd2, 3'd2, 3'd3, 3'd0}, // R1 first access: ACT RD
        '{1'b0, 1'b1, 2'd0, 13'd5, 10'd40,   3'd1, 2'd1, 3'd4, 3'd0, 3'd0}, // R2 hit: WR
        '{1'b0, 1'b0, 2'd0, 13'd9, 10'd2,    3'd0, 2'd3, 3'd1, 3'd2, 3'd3}, // R3 conflict
        '{1'b0, 1'b1, 2'd2, 13'd7, 10'd100,  3'd7, 2'd2, 3'd2, 3'd4, 3'd0}, // R4 idle bank
        '{1'b0, 1'b0, 2'd0, 13'd9, 10'd3,    3'd2, 2'd1, 3'd3, 3'd0, 3'd0}, // R4 bank0 kept
        '{1'b1, 1'b0, 2'd0, 13'd0, 10'd0,    3'd0, 2'd2, 3'd5, 3'd6, 3'd0}, // R7 refresh
        '{1'b0, 1'b0, 2'd2, 13'd7, 10'd5,    3'd4, 2'd2, 3'd2, 3'd3, 3'd0}, // R7 closed after
        '{1'b0, 1'b1, 2'd2, 13'd7, 10'h3FF,  3'd7, 2'd1, 3'd4, 3'd0, 3'd0}  // R11 col max
    };

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual %0d expected 0", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rdy_at;
        rst = 1'b1; clr = 1'b0; req_valid = 1'b0; req_refresh = 1'b0; req_write = 1'b0;
        req_bank = '0; req_row = '0; req_col = '0; req_burst = '0;
        en_pre = 4'hF; en_act = 4'hF; en_rd = 4'hF; en_wr = 4'hF; en_pall = 1'b1; en_ref = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1.5;
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R1 no cmd after reset", int'(cmd_valid), 0);
        chk("R13 code idle", int'(cmd_code), 0);
        chk("R1 done low after reset", int'(done), 0);

        for (int i = 0; i < 8; i++) begin
            vec_t v;
            v = VECS[i];
            send(v.rf, v.wr, v.bank, v.row, v.col, v.burst);
            wait_ready(rdy_at);
            chk($sformatf("R2/R3/R4 vec%0d count", i), lg_n, int'(v.n));
            chk($sformatf("R3 vec%0d code0", i), int'(lg_code[0]), int'(v.c0));
            if (v.n > 1) chk($sformatf("R3 vec%0d code1", i), int'(lg_code[1]), int'(v.c1));
            if (v.n > 2) chk($sformatf("R3 vec%0d code2", i), int'(lg_code[2]), int'(v.c2));
            chk($sformatf("R10 vec%0d done count", i), done_n, 1);
            if (lg_n > 0) chk($sformatf("R10 vec%0d done on last", i), int'(lg_done[lg_n-1]), 1);
            for (int k = 0; k < lg_n; k++) begin
                if (!v.rf) chk($sformatf("R3 vec%0d bank%0d", i, k), int'(lg_bank[k]), int'(v.bank));
                if (lg_code[k] == C_ACT)
                    chk($sformatf("R11 vec%0d act row", i), int'(lg_addr[k]), int'(v.row));
                if (lg_code[k] == C_RD || lg_code[k] == C_WR) begin
                    chk($sformatf("R11 vec%0d col", i), int'(lg_addr[k]), int'(v.col));
                    chk($sformatf("R11 vec%0d burst", i), int'(lg_burst[k]), int'(v.burst));
                end
            end
            if (v.n == 3 && lg_n == 3) begin
                chk("R5 pre to act gap", lg_cyc[1] - lg_cyc[0], TRP);
                chk("R6 act to rw gap", lg_cyc[2] - lg_cyc[1], TRCD);
            end
            if (v.n == 2 && v.c0 == C_ACT && lg_n == 2)
                chk("R6 act to rw gap", lg_cyc[1] - lg_cyc[0], TRCD);
            if (v.rf && lg_n == 2) begin
                chk("R7 pall to ref gap", lg_cyc[1] - lg_cyc[0], TRP);
                chk("R8 ref to ready gap", rdy_at - lg_cyc[1], TRFC);
            end
        end

        // R9: only another bank's activate enable is high
        @(negedge clk);
        en_act = 4'b0010;
        send(1'b0, 1'b0, 2'd3, 13'd11, 10'd9, 3'd1);
        repeat (6) @(negedge clk);
        chk("R9 act held while enable low", lg_n, 0);
        en_act = 4'hF;
        wait_ready(rdy_at);
        chk("R9 single act then rd", lg_n, 2);
        chk("R9 first is act", int'(lg_code[0]), int'(C_ACT));
        chk("R9 then rd", int'(lg_code[1]), int'(C_RD));

        // R12: clear between activate and read
        en_rd = 4'h0;
        send(1'b0, 1'b0, 2'd1, 13'd3, 10'd4, 3'd0);
        repeat (4) @(negedge clk);
        chk("R12 act issued before clear", lg_n, 1);
        chk("R9 rd held", int'(req_ready), 0);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        #1.5;
        chk("R12 ready after clear", int'(req_ready), 1);
        chk("R12 no rd issued", lg_n, 1);
        en_rd = 4'hF;
        send(1'b0, 1'b0, 2'd1, 13'd3, 10'd4, 3'd0);
        wait_ready(rdy_at);
        chk("R12 bank closed by clear", lg_n, 2);
        chk("R12 act after clear", int'(lg_code[0]), int'(C_ACT));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule